// File: doc/BRIEF.md
# Pairwise Widening Add-Accumulate Vector Unit

This unit performs one vector operation. It splits a source vector into narrow integer elements and adds each pair of neighbouring elements. Each pair sum is widened to twice the element width and added into the matching wide lane of a destination vector. The element width, the signed or unsigned reading and the vector length come from a 32-bit instruction word. A small decoder inside the unit extracts these fields from the word. The caller provides the source vector and the current destination value together with the word. It receives the updated destination one cycle after the request is accepted.

Requests come in on a valid/ready stream, and results go out on a second valid/ready stream. The output stage is a single register. A new request is accepted when that register is empty, or when its content is being taken in the same cycle. While the consumer holds `out_ready` low, the result stays on the output and `in_ready` is low. A request offered during that time waits, and its input signals are expected to stay constant until it is accepted. No condition flags are produced.

Top module: `pal_unit`

## Requirements
- R1: The decoder reads element size from word bits [19:18]: 00 means 8-bit, 01 means 16-bit, 10 means 32-bit. Bit 7 selects the signedness: 0 means signed, 1 means unsigned. Bit 6 selects the length: 1 means quadword (128 bits), 0 means doubleword (64 bits).
- R2: Elements are numbered from the least significant bits. Wide result lane e equals destination lane e plus source elements 2e and 2e+1.
- R3: In unsigned mode, each source element is zero-extended to double width before the pair is added.
- R4: In signed mode, each source element is sign-extended to double width before the pair is added.
- R5: Each wide lane wraps modulo 2^(2*element width), with no saturation and no carry into the neighbouring lane.
- R6: In doubleword mode, only bits [63:0] are computed. Bits [127:64] of the output equal bits [127:64] of the destination.
- R7: In quadword mode, both 64-bit halves are computed in the same way.
- R8: The word is illegal when its size code is 11, when bits [17:16] are not 00, or when bits [11:8] are not 0110. An illegal word sets `out_illegal` to 1 and returns the destination unchanged. A legal word sets `out_illegal` to 0.
- R9: `in_ready` is high when the output register is empty or `out_ready` is high. A request accepted at a clock edge shows up on the output after that edge. A result that is not taken keeps its data and its valid strobe unchanged.
- R10: A synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_insn | input | 32 | Instruction word holding the size, signedness and length fields |
| in_src | input | 128 | Source vector of narrow elements |
| in_dst | input | 128 | Current destination vector of wide lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Updated destination vector |
| out_illegal | output | 1 | The instruction word was rejected |

## Verification
The assertions assume that a request waiting for acceptance keeps its word and vectors steady. They also assume that reset is applied for at least one clock before traffic starts. The bench changes its inputs only on falling edges. It raises `in_valid` only after reset has been released. During a stall it keeps the pending request unchanged until the edge at which the request is accepted.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    ESZ8  = 2'b00,
    ESZ16 = 2'b01,
    ESZ32 = 2'b10,
    ESZX  = 2'b11
  } esz_e;

  typedef struct packed {
    esz_e size;
    logic is_signed;
    logic quad;
    logic illegal;
  } pal_ctl_t;
endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_pkg::*;
(
  input  logic [31:0] insn,
  output pal_ctl_t    ctl
);
  localparam int SIZE_LO = 18;
  localparam int OP_BIT  = 7;
  localparam int Q_BIT   = 6;

  logic pattern_ok;

  always_comb begin
    pattern_ok    = (insn[17:16] == 2'b00) && (insn[11:8] == 4'b0110);
    ctl.size      = esz_e'(insn[SIZE_LO+1:SIZE_LO]);
    ctl.is_signed = ~insn[OP_BIT];
    ctl.quad      = insn[Q_BIT];
    ctl.illegal   = !pattern_ok || (ctl.size == ESZX);
  end
endmodule

// File: rtl/pal_lanes.sv
module pal_lanes #(
  parameter int VEC_W = 128,
  parameter int ESZ   = 8
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic             is_signed,
  output logic [VEC_W-1:0] res
);
  localparam int WW = 2 * ESZ;
  localparam int NL = VEC_W / WW;

  for (genvar e = 0; e < NL; e++) begin : g_lane
    logic [ESZ-1:0] lo_el;
    logic [ESZ-1:0] hi_el;
    logic [WW-1:0]  lo_ext;
    logic [WW-1:0]  hi_ext;

    assign lo_el  = src[(2*e)*ESZ +: ESZ];
    assign hi_el  = src[(2*e+1)*ESZ +: ESZ];
    assign lo_ext = {{ESZ{is_signed & lo_el[ESZ-1]}}, lo_el};
    assign hi_ext = {{ESZ{is_signed & hi_el[ESZ-1]}}, hi_el};
    assign res[e*WW +: WW] = dst[e*WW +: WW] + lo_ext + hi_ext;
  end
endmodule

// File: rtl/pal_unit.sv
module pal_unit
  import pal_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_insn,
  input  logic [VEC_W-1:0] in_src,
  input  logic [VEC_W-1:0] in_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_illegal
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NSZ    = 3;

  pal_ctl_t         ctl;
  logic [VEC_W-1:0] sz_res [NSZ];
  logic [VEC_W-1:0] pick;
  logic [VEC_W-1:0] next_data;
  logic             fire_in;

  pal_decode u_dec (
    .insn (in_insn),
    .ctl  (ctl)
  );

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    pal_lanes #(.VEC_W(VEC_W), .ESZ(8 << s)) u_lanes (
      .src       (in_src),
      .dst       (in_dst),
      .is_signed (ctl.is_signed),
      .res       (sz_res[s])
    );
  end

  always_comb begin
    case (ctl.size)
      ESZ8:    pick = sz_res[0];
      ESZ16:   pick = sz_res[1];
      ESZ32:   pick = sz_res[2];
      default: pick = in_dst;
    endcase
    if (ctl.illegal)
      next_data = in_dst;
    else if (ctl.quad)
      next_data = pick;
    else
      next_data = {in_dst[VEC_W-1:HALF_W], pick[HALF_W-1:0]};
  end

  assign in_ready = !out_valid || out_ready;
  assign fire_in  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)
      out_valid <= 1'b0;
    else if (in_ready)
      out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (fire_in) begin
      out_data    <= next_data;
      out_illegal <= ctl.illegal;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R10
  AST_FIRE_TO_OUT: assert property (@(posedge clk) disable iff (rst)
    fire_in |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal))); // R9
  AST_ILLEGAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (fire_in && ctl.illegal) |=> (out_illegal && out_data == $past(in_dst))); // R8
  AST_DBL_UPPER: assert property (@(posedge clk) disable iff (rst)
    (fire_in && !ctl.quad) |=> (out_data[VEC_W-1:HALF_W] == $past(in_dst[VEC_W-1:HALF_W]))); // R6
  AST_SIZE3_REJECT: assert property (@(posedge clk) disable iff (rst)
    (fire_in && in_insn[19:18] == 2'b11) |=> out_illegal); // R8
endmodule

// File: tb/tb_pal_unit.sv
module tb_pal_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_insn;
  logic [127:0] in_src;
  logic [127:0] in_dst;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic         out_illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pal_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic op, input logic q);
    logic [31:0] w;
    w = 32'hF3B00600;
    w[19:18] = sz;
    w[7] = op;
    w[6] = q;
    return w;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic [1:0] sz, input logic op, input logic q);
    logic [127:0] r;
    int es, ww, nl;
    logic [63:0] m1, m2, a, b, dl, sum;
    r  = d;
    es = 8 << sz;
    ww = 2 * es;
    nl = (q ? 128 : 64) / ww;
    m1 = (64'd1 << es) - 1;
    m2 = (ww == 64) ? '1 : ((64'd1 << ww) - 1);
    for (int e = 0; e < nl; e++) begin
      a  = 64'(s >> (2*e*es)) & m1;
      b  = 64'(s >> ((2*e+1)*es)) & m1;
      dl = 64'(d >> (e*ww)) & m2;
      if (!op && a[es-1]) a = a | ~m1;
      if (!op && b[es-1]) b = b | ~m1;
      sum = (dl + a + b) & m2;
      r = (r & ~(128'(m2) << (e*ww))) | (128'(sum) << (e*ww));
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transfer with out_ready high; sample at the falling edge after acceptance
  task automatic run(input string req, input logic [31:0] w, input logic [127:0] s,
                     input logic [127:0] d, input logic [127:0] exp, input logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_src = s; in_dst = d; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 128'(out_valid), 128'd1);
    chk({req, " data"}, out_data, exp);
    chk({req, " illegal"}, 128'(out_illegal), 128'(exp_ill));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] s, d;
    logic [31:0] w;
    void'($urandom(7));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_insn = '0; in_src = '0; in_dst = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 128'(out_valid), 128'd0);
    chk("R9 ready when empty", 128'(in_ready), 128'd1);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7: sweep every legal size, sign and length
    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 2; op++)
        for (int q = 0; q < 2; q++)
          for (int k = 0; k < 12; k++) begin
            s = {$urandom, $urandom, $urandom, $urandom};
            d = {$urandom, $urandom, $urandom, $urandom};
            if (k == 0) begin s = '1; d = '1; end          // R5 wrap all ones
            if (k == 1) begin s = {16{8'h80}}; d = '0; end // R4 most negative
            if (k == 2) begin s = {16{8'h7F}}; d = '0; end
            w = mk(2'(sz), op[0], q[0]);
            run(q ? "R7 quad" : "R6 dbl", w, s, d, model(s, d, 2'(sz), op[0], q[0]), 1'b0);
          end

    // R3 / R4 spot values, 8-bit, doubleword: 0xFF + 0xFF
    run("R3 unsigned ext", mk(2'b00, 1'b1, 1'b0), 128'hFFFF, 128'h0,
        128'h01FE, 1'b0);
    run("R4 signed ext", mk(2'b00, 1'b0, 1'b0), 128'hFFFF, 128'h0,
        128'hFFFE, 1'b0);
    // R5 wrap in 16-bit lanes, no carry into lane 1
    run("R5 wrap", mk(2'b00, 1'b1, 1'b0), 128'h0101, 128'h0000_FFFF,
        128'h0000_0001, 1'b0);
    // R2 pairing order, 16-bit elements
    run("R2 pairing", mk(2'b01, 1'b1, 1'b1), 128'h0004_0003_0002_0001,
        128'h0, 128'h7_0000_0003, 1'b0);

    // R8 illegal words
    d = {$urandom, $urandom, $urandom, $urandom};
    run("R8 size11", mk(2'b11, 1'b0, 1'b1), '1, d, d, 1'b1);
    w = mk(2'b00, 1'b0, 1'b1); w[16] = 1'b1;
    run("R8 bits17_16", w, '1, d, d, 1'b1);
    w = mk(2'b01, 1'b1, 1'b1); w[9] = 1'b0;
    run("R8 bits11_8", w, '1, d, d, 1'b1);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_insn = mk(2'b00, 1'b1, 1'b1); in_src = 128'h0101; in_dst = 128'h0;
    @(negedge clk);
    chk("R9 accepted A", out_data, 128'h2);
    chk("R9 ready low on stall", 128'(in_ready), 128'd0);
    in_src = 128'h0202;
    @(negedge clk);
    chk("R9 held valid", 128'(out_valid), 128'd1);
    chk("R9 held data", out_data, 128'h2);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 B after release", out_data, 128'h4);
    @(negedge clk);
    chk("R9 drained", 128'(out_valid), 128'd0);

    // R10 reset mid-stream
    out_ready = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears valid", 128'(out_valid), 128'd0);
    rst = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule